// File: doc/BRIEF.md
# BERT Receive Pattern Synchronizer

This block is the receiving half of a bit error rate tester. It keeps a local copy of the test pattern generator and locks it onto the incoming serial stream. While it is hunting, every received bit is shifted into the generator history. Once it is locked, the generator runs on its own prediction, and each received bit is compared with the predicted bit. For every bit received while locked, the block reports one bit-count increment, plus an error-count increment when the two bits differ. The counters that add up these increments belong to a neighbouring block.

The pattern is either pseudorandom or repetitive. Its length field L gives a history of L+1 bits. A tap field selects the second feedback point for pseudorandom mode, and a 32-bit seed preloads the history. A rising edge on the load strobe takes a new configuration. A rising edge on the resync strobe restarts the hunt. If too many errors arrive within a bit window, the block can drop lock by itself, and software can turn that behaviour off.

Top module: `bert_rx_sync`

## Requirements
- R1: On the clock edge where `load_req` is 1 and was 0 at the previous edge, the block captures `cfg_prbs`, `cfg_len`, `cfg_tap` and `cfg_seed`, copies the seed into the history (bit 0 holds the newest bit), and drops `in_sync`. Keeping `load_req` at 1 after that edge has no further effect.
- R2: When `invert` is 1, each received bit is complemented before it is compared. When `invert` is 0, the bit is compared as received.
- R3: While out of sync, `in_sync` rises at the edge of the 32nd consecutive bit that matches the prediction. A mismatch sets the run count back to zero, and the bit that mismatched is still shifted into the history.
- R4: `bit_inc` is 1 for exactly one cycle after each bit that was received while `in_sync` was 1. It is 0 for bits received while out of sync, and for the bit on which a load or resync edge occurs.
- R5: `err_inc` is 1 for each in-sync bit that differs from the prediction.
- R6: When automatic resync is enabled (`auto_off`=0), the 6th mismatch within a 64-bit window drops `in_sync` at the edge of that bit. Five mismatches within a window leave the block in sync.
- R7: The 64-bit windows are counted from the first bit after lock is gained. At the end of each window the mismatch count returns to zero.
- R8: When `auto_off` is 1, mismatches never drop `in_sync`.
- R9: A 0-to-1 transition of `resync_req` drops `in_sync` and starts a new 32-bit hunt. Keeping `resync_req` high after that edge does not restart the hunt again.
- R10: The predicted bit is `h[len] ^ h[tap]` when `cfg_prbs`=1, and `h[len]` when `cfg_prbs`=0, where `h` is the history. While locked, the predicted bit is shifted into the history in place of the received bit.
- R11: While `rst_n` is 0, `in_sync`, `bit_inc` and `err_inc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 1 | Received serial bit |
| load_req | input | 1 | Pattern load strobe, acts on its rising edge |
| resync_req | input | 1 | Manual resync strobe, acts on its rising edge |
| invert | input | 1 | Complements received data before it is compared |
| auto_off | input | 1 | 1 turns off automatic loss of sync |
| cfg_prbs | input | 1 | 1 selects pseudorandom mode, 0 selects repetitive mode |
| cfg_len | input | 5 | Pattern length minus one |
| cfg_tap | input | 5 | Feedback tap position for pseudorandom mode |
| cfg_seed | input | 32 | Preload value for the history |
| in_sync | output | 1 | Lock status |
| bit_inc | output | 1 | One-cycle bit-count increment |
| err_inc | output | 1 | One-cycle error-count increment |

## Verification
All three outputs are registered. The effect of a bit that is presented before edge k can be seen after edge k. The bench therefore drives each input on a falling edge and reads the outputs on the next falling edge. Lock is checked at the exact bit: not set after the 31st matching bit, set after the 32nd. Loss of sync is checked after the 5th and after the 6th error of a window, at window positions that the bench counts from the lock edge.

// File: rtl/bert_rx_pkg.sv
// Shared types for the BERT receive synchronizer.
// Assumes a history of at most 32 bits.
package bert_rx_pkg;
    localparam int PAT_W = 32;
    localparam int IDX_W = $clog2(PAT_W);

    typedef struct packed {
        logic             prbs;
        logic [IDX_W-1:0] len;
        logic [IDX_W-1:0] tap;
        logic [PAT_W-1:0] seed;
    } pat_cfg_t;
endpackage

// File: rtl/bert_rx_rise.sv
// Rising-edge detector for N level strobes.
// The output is a one-cycle pulse at the first edge where the input is 1.
// Assumes the strobes are synchronous to clk.
module bert_rx_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // remember the level from the previous edge
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign evt[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/bert_rx_patgen.sv
// Local pattern generator with a shift-register history.
// Bit 0 of the history is the newest bit.
// It predicts the next bit from the history. While hunting it shifts in
// the received bit; while locked it shifts in its own prediction.
// Assumes cfg is stable in the cycle where load_evt is 1.
module bert_rx_patgen
    import bert_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_evt,
    input  pat_cfg_t cfg,
    input  logic     locked,
    input  logic     rx_bit,
    output logic     pred
);
    logic             prbs_q;
    logic [IDX_W-1:0] len_q;
    logic [IDX_W-1:0] tap_q;
    logic [PAT_W-1:0] hist_q;

    // prediction: pseudorandom adds the tap term, repetitive repeats L+1 back
    always_comb pred = hist_q[len_q] ^ (prbs_q & hist_q[tap_q]);

    // active configuration and history update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prbs_q <= 1'b0;
            len_q  <= '0;
            tap_q  <= '0;
            hist_q <= '0;
        end else if (load_evt) begin
            prbs_q <= cfg.prbs;
            len_q  <= cfg.len;
            tap_q  <= cfg.tap;
            hist_q <= cfg.seed;
        end else begin
            hist_q <= {hist_q[PAT_W-2:0], locked ? pred : rx_bit};
        end
    end
endmodule

// File: rtl/bert_rx_monitor.sv
// Sync state machine and error window.
// It declares lock after LOCK_RUN consecutive matches. While locked it
// emits bit and error increments, and it drops lock on the ERR_LIMIT-th
// mismatch in a WIN_LEN-bit window unless auto_off is set.
// Assumes one bit is received on every clock edge.
module bert_rx_monitor #(
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    parameter int LOCK_RUN  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic auto_off,
    input  logic mismatch,
    output logic in_sync,
    output logic bit_inc,
    output logic err_inc
);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int RUN_W = $clog2(LOCK_RUN);
    localparam int ERR_W = $clog2(ERR_LIMIT);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
    localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_LIMIT - 1);

    logic [RUN_W-1:0] run_q;
    logic [WIN_W-1:0] win_q;
    logic [ERR_W-1:0] errs_q;

    // hunt, lock and window bookkeeping with registered increments
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync <= 1'b0;
            bit_inc <= 1'b0;
            err_inc <= 1'b0;
            run_q   <= '0;
            win_q   <= '0;
            errs_q  <= '0;
        end else begin
            bit_inc <= 1'b0;
            err_inc <= 1'b0;
            if (restart) begin
                in_sync <= 1'b0;
                run_q   <= '0;
            end else if (!in_sync) begin
                if (mismatch) begin
                    run_q <= '0;
                end else if (run_q == RUN_LAST) begin
                    in_sync <= 1'b1;
                    run_q   <= '0;
                    win_q   <= '0;
                    errs_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                bit_inc <= 1'b1;
                err_inc <= mismatch;
                if (mismatch && !auto_off && errs_q == ERR_LAST) begin
                    in_sync <= 1'b0;
                    run_q   <= '0;
                end else begin
                    win_q <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
                    if (win_q == WIN_LAST)
                        errs_q <= '0;
                    else if (mismatch && errs_q != ERR_LAST)
                        errs_q <= errs_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bert_rx_sync.sv
// Top of the BERT receive synchronizer.
// It detects the strobe edges, applies the optional inversion, and
// connects the pattern generator to the sync monitor.
// Assumes the configuration stays stable around the load edge.
module bert_rx_sync
    import bert_rx_pkg::*;
#(
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    parameter int LOCK_RUN  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_data,
    input  logic             load_req,
    input  logic             resync_req,
    input  logic             invert,
    input  logic             auto_off,
    input  logic             cfg_prbs,
    input  logic [IDX_W-1:0] cfg_len,
    input  logic [IDX_W-1:0] cfg_tap,
    input  logic [PAT_W-1:0] cfg_seed,
    output logic             in_sync,
    output logic             bit_inc,
    output logic             err_inc
);
    logic [1:0] evt;
    logic       rx_bit;
    logic       pred;
    logic       mismatch;
    pat_cfg_t   cfg;

    // gather the configuration fields
    always_comb cfg = '{prbs: cfg_prbs, len: cfg_len, tap: cfg_tap, seed: cfg_seed};
    // optional inversion, then comparison with the prediction
    always_comb rx_bit   = rx_data ^ invert;
    always_comb mismatch = rx_bit ^ pred;

    bert_rx_rise #(.N(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({resync_req, load_req}),
        .evt   (evt)
    );

    bert_rx_patgen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_evt (evt[0]),
        .cfg      (cfg),
        .locked   (in_sync),
        .rx_bit   (rx_bit),
        .pred     (pred)
    );

    bert_rx_monitor #(
        .WIN_LEN   (WIN_LEN),
        .ERR_LIMIT (ERR_LIMIT),
        .LOCK_RUN  (LOCK_RUN)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (evt[0] | evt[1]),
        .auto_off (auto_off),
        .mismatch (mismatch),
        .in_sync  (in_sync),
        .bit_inc  (bit_inc),
        .err_inc  (err_inc)
    );
endmodule

// File: rtl/bert_rx_sync_chk.sv
// Port-level properties for bert_rx_sync, attached with bind.
module bert_rx_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic load_req,
    input logic resync_req,
    input logic auto_off,
    input logic in_sync,
    input logic bit_inc,
    input logic err_inc
);
    AST_LOAD_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !$past(load_req)) |=> !in_sync); // R1
    AST_RESYNC_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_req && !$past(resync_req)) |=> !in_sync); // R9
    AST_BIT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_inc |-> $past(in_sync)); // R4
    AST_ERR_IMPLIES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        err_inc |-> bit_inc); // R5
    AST_LOCK_BIT_UNCOUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> !bit_inc); // R3
    AST_AUTO_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && auto_off && !(load_req && !$past(load_req))
         && !(resync_req && !$past(resync_req))) |=> in_sync); // R8
endmodule

bind bert_rx_sync bert_rx_sync_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (load_req),
    .resync_req (resync_req),
    .auto_off   (auto_off),
    .in_sync    (in_sync),
    .bit_inc    (bit_inc),
    .err_inc    (err_inc)
);

// File: tb/sim_bert_rx_sync.sv
module sim_bert_rx_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_data = 1'b0;
    logic        load_req = 1'b0;
    logic        resync_req = 1'b0;
    logic        invert = 1'b0;
    logic        auto_off = 1'b0;
    logic        cfg_prbs = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic [4:0]  cfg_tap = '0;
    logic [31:0] cfg_seed = '0;
    logic        in_sync, bit_inc, err_inc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference pattern model
    logic [31:0] m_h;
    logic [4:0]  m_len, m_tap;
    logic        m_prbs, m_inv;

    always #4 clk = ~clk;

    bert_rx_sync u0 (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .load_req(load_req),
        .resync_req(resync_req), .invert(invert), .auto_off(auto_off),
        .cfg_prbs(cfg_prbs), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
        .cfg_seed(cfg_seed), .in_sync(in_sync), .bit_inc(bit_inc),
        .err_inc(err_inc)
    );

    typedef struct packed {
        logic        prbs;
        logic [4:0]  len;
        logic [4:0]  tap;
        logic [31:0] seed;
        logic        inv;
        logic [6:0]  lock_at;
    } vec_t;

    localparam vec_t TBL [4] = '{
        '{prbs:1'b1, len:5'd6, tap:5'd5, seed:32'h0000_005A, inv:1'b0, lock_at:7'd32},
        '{prbs:1'b1, len:5'd6, tap:5'd5, seed:32'h0000_0013, inv:1'b1, lock_at:7'd32},
        '{prbs:1'b0, len:5'd7, tap:5'd0, seed:32'h0000_00B2, inv:1'b0, lock_at:7'd32},
        '{prbs:1'b1, len:5'd4, tap:5'd2, seed:32'h0000_0019, inv:1'b0, lock_at:7'd32}
    };

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic feed(input bit flip);
        logic e;
        e = m_h[m_len] ^ (m_prbs & m_h[m_tap]);
        m_h = {m_h[30:0], e};
        rx_data = e ^ m_inv ^ flip;
        step();
    endtask

    task automatic load(input vec_t v, input bit hold);
        cfg_prbs = v.prbs; cfg_len = v.len; cfg_tap = v.tap; cfg_seed = v.seed;
        invert = v.inv;
        m_prbs = v.prbs; m_len = v.len; m_tap = v.tap; m_h = v.seed; m_inv = v.inv;
        load_req = 1'b1;
        rx_data = 1'b0;
        step();
        if (!hold) load_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R): actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        chk(in_sync, 1'b0, "R11 in_sync in reset");
        chk(bit_inc, 1'b0, "R11 bit_inc in reset");
        chk(err_inc, 1'b0, "R11 err_inc in reset");
        rst_n = 1'b1;

        // table walk: lock exactly at the 32nd matching bit, then clean counting (R2 R10)
        for (int i = 0; i < 4; i++) begin
            load(TBL[i], 1'b0);
            chk(in_sync, 1'b0, "R1 out of sync after load");
            for (int b = 1; b <= 40; b++) begin
                feed(1'b0);
                if (b == TBL[i].lock_at - 1) chk(in_sync, 1'b0, "R3 R10 R2 not yet locked");
                if (b == TBL[i].lock_at) begin
                    chk(in_sync, 1'b1, "R3 R10 R2 locked");
                    chk(bit_inc, 1'b0, "R4 lock bit uncounted");
                end
                if (b == 40) begin
                    chk(bit_inc, 1'b1, "R4 bit_inc while locked");
                    chk(err_inc, 1'b0, "R5 no error on clean bit");
                end
            end
        end

        // a mismatch during hunt restarts the run (repetitive, length 8)
        load(TBL[2], 1'b0);
        for (int b = 1; b <= 51; b++) begin
            feed(b == 11);
            if (b == 50) chk(in_sync, 1'b0, "R3 run restarted");
            if (b == 51) chk(in_sync, 1'b1, "R3 lock after restart");
        end

        // window 1: five errors keep lock
        for (int p = 0; p < 64; p++) begin
            bit f;
            f = (p == 2 || p == 4 || p == 6 || p == 8 || p == 10);
            feed(f);
            if (f) chk(err_inc, 1'b1, "R5 err_inc on mismatch");
            if (p == 3) chk(err_inc, 1'b0, "R5 no err on clean bit");
        end
        chk(in_sync, 1'b1, "R6 five errors keep lock");
        // window 2: one error, then five more reach six
        feed(1'b1);
        chk(in_sync, 1'b1, "R7 window restarted count");
        for (int p = 1; p < 10; p++) feed(1'b0);
        for (int p = 10; p <= 14; p++) begin
            feed(1'b1);
            if (p == 13) chk(in_sync, 1'b1, "R6 five in window still locked");
            if (p == 14) begin
                chk(in_sync, 1'b0, "R6 sixth error drops lock");
                chk(err_inc, 1'b1, "R5 sixth error counted");
            end
        end
        feed(1'b0);
        chk(bit_inc, 1'b0, "R4 no bit_inc while hunting");
        for (int b = 2; b <= 32; b++) begin
            feed(1'b0);
            if (b == 31) chk(in_sync, 1'b0, "R3 relock not early");
            if (b == 32) chk(in_sync, 1'b1, "R3 relock after auto drop");
        end

        // auto resync disabled
        auto_off = 1'b1;
        for (int b = 0; b < 10; b++) begin
            feed(1'b1);
            chk(err_inc, 1'b1, "R8 errors still reported");
        end
        chk(in_sync, 1'b1, "R8 lock held with auto_off");

        // manual resync, held high
        resync_req = 1'b1;
        feed(1'b0);
        chk(in_sync, 1'b0, "R9 resync drops lock");
        chk(bit_inc, 1'b0, "R4 resync bit uncounted");
        for (int b = 1; b <= 32; b++) begin
            feed(1'b0);
            if (b == 31) chk(in_sync, 1'b0, "R9 hunting after resync");
            if (b == 32) chk(in_sync, 1'b1, "R9 held strobe no retrigger");
        end
        resync_req = 1'b0;
        auto_off = 1'b0;
        feed(1'b0);
        chk(bit_inc, 1'b1, "R4 counting after resync lock");

        // load while locked, strobe held high
        load(TBL[0], 1'b1);
        chk(in_sync, 1'b0, "R1 load drops lock");
        chk(bit_inc, 1'b0, "R4 load bit uncounted");
        for (int b = 1; b <= 32; b++) begin
            feed(1'b0);
            if (b == 32) chk(in_sync, 1'b1, "R1 held load no reload");
        end
        load_req = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule